// File: doc/BRIEF.md
# Per-Destination Interrupt Priority Delivery

This block keeps the interrupt state of a single processor destination. It records two sets of interrupt sources: those currently raised toward the processor and those the processor is servicing. Each source carries a 4-bit priority. The block finds the best source in each set. It asserts the normal interrupt line only when the best raised priority is above both the processor's task-priority threshold and the best in-service priority.

A raised source is recorded even when its priority is too low to interrupt. A later lowering of the threshold, or the end of servicing, can then release it without the source being signalled again. Sources routed to the critical or machine-check outputs bypass the priority logic. They are tracked with one reference counter per output, and that output stays high while its count is non-zero.

Events arrive on one event port (source index, priority, output type, new and previous activity), one threshold write port and one in-service port. Every output is registered. Each output reflects the state after the clock edge that accepts a stimulus.

Top module: `prio_deliver`

## Requirements
- R1: After reset, int_o, crit_o and mcp_o are 0. Both reported best indices and both reported priorities are all ones (-1), and the threshold is 15.
- R2: A normal-type activation (evt_out = 0, evt_active = 1) always adds the source to the raised set and stores its priority, even when that priority is at or below the threshold.
- R3: The best source of a set is the one with the highest priority. On equal priority, the lowest index wins. An empty set reports index -1 and priority -1.
- R4: int_o is 1 exactly when the raised set is non-empty and its best priority is strictly greater than the threshold and strictly greater than the best in-service priority (-1 when nothing is in service).
- R5: A normal-type deactivation (evt_active = 0) removes the source from the raised set. int_o then follows R4 over the remaining sources.
- R6: A threshold write (ctpr_we) is applied together with any event in the same cycle. A lowered threshold releases a raised source that was held back.
- R7: svc_we with svc_set = 1 adds svc_src to the in-service set, and svc_set = 0 removes it. Its priority is the priority last stored for that source.
- R8: Critical-type events (evt_out = 1) count up on active with previous-inactive and count down on inactive with previous-active. crit_o is 1 while the count is non-zero, and the count never goes below 0.
- R9: Machine-check-type events (evt_out = 2) drive mcp_o with their own counter under the same rules as R8.
- R10: Critical and machine-check events leave both sets and int_o unchanged. Normal events leave both counters unchanged. Type 3 has no effect.
- R11: Every output reflects the state after the rising clock edge that accepts the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event strobe |
| evt_active | input | 1 | New activity of the source |
| evt_was_active | input | 1 | Previous activity of the source |
| evt_out | input | 2 | Output type: 0 normal, 1 critical, 2 machine check |
| evt_src | input | IW | Source index |
| evt_prio | input | PW | Source priority |
| ctpr_we | input | 1 | Threshold write strobe |
| ctpr_data | input | PW | New threshold |
| svc_we | input | 1 | In-service update strobe |
| svc_set | input | 1 | 1 marks the source in service, 0 clears it |
| svc_src | input | IW | In-service source index |
| int_o | output | 1 | Normal interrupt line |
| crit_o | output | 1 | Critical interrupt line |
| mcp_o | output | 1 | Machine-check line |
| rsd_best_o | output | IW+1 | Best raised index, all ones if none |
| rsd_pri_o | output | PW+1 | Best raised priority, all ones if none |
| svc_best_o | output | IW+1 | Best in-service index, all ones if none |
| svc_pri_o | output | PW+1 | Best in-service priority, all ones if none |

## Verification
Every result of this block appears one clock edge after the stimulus. The selection trees and the threshold comparison work on the next-cycle state, and only the final results are registered. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It compares all outputs at that second falling edge, which falls after exactly one rising edge. Expected values come from a bench model of the two sets, the stored priorities, the threshold and the counters. The sweep covers every pair of threshold and priority values.

// File: rtl/prio_deliver.sv
module prio_deliver #(
  parameter int NSRC = 64,
  parameter int PW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  input  logic                    evt_active,
  input  logic                    evt_was_active,
  input  logic [1:0]              evt_out,
  input  logic [$clog2(NSRC)-1:0] evt_src,
  input  logic [PW-1:0]           evt_prio,
  input  logic                    ctpr_we,
  input  logic [PW-1:0]           ctpr_data,
  input  logic                    svc_we,
  input  logic                    svc_set,
  input  logic [$clog2(NSRC)-1:0] svc_src,
  output logic                    int_o,
  output logic                    crit_o,
  output logic                    mcp_o,
  output logic [$clog2(NSRC):0]   rsd_best_o,
  output logic [PW:0]             rsd_pri_o,
  output logic [$clog2(NSRC):0]   svc_best_o,
  output logic [PW:0]             svc_pri_o
);
  localparam int IW = $clog2(NSRC);
  localparam int CW = $clog2(NSRC + 1);
  localparam int BW = IW + PW + 1;
  localparam logic [1:0] OUT_NORM = 2'd0;

  logic [NSRC-1:0] rsd_q, rsd_n, svc_q, svc_n;
  logic [PW-1:0]   pri_q [NSRC];
  logic [PW-1:0]   pri_n [NSRC];
  logic [PW-1:0]   ctpr_q, ctpr_n;
  logic [BW-1:0]   rb, sb, rb_q, sb_q;
  logic            int_n, int_q;
  logic [CW-1:0]   cnt_q [2];

  function automatic logic [BW-1:0] best_of(input logic [NSRC-1:0] s,
                                            input logic [PW-1:0] p [NSRC]);
    logic          found;
    logic [IW-1:0] bi;
    logic [PW-1:0] bp;
    found = 1'b0;
    bi = '0;
    bp = '0;
    for (int i = 0; i < NSRC; i++)
      if (s[i] && (!found || p[i] > bp)) begin
        found = 1'b1;
        bi = IW'(i);
        bp = p[i];
      end
    return {found, bi, bp};
  endfunction

  always_comb begin
    rsd_n = rsd_q;
    svc_n = svc_q;
    pri_n = pri_q;
    if (evt_valid && evt_out == OUT_NORM) begin
      rsd_n[evt_src] = evt_active;
      if (evt_active) pri_n[evt_src] = evt_prio;
    end
    if (svc_we) svc_n[svc_src] = svc_set;
  end

  assign ctpr_n = ctpr_we ? ctpr_data : ctpr_q;
  assign rb = best_of(rsd_n, pri_n);
  assign sb = best_of(svc_n, pri_n);
  assign int_n = rb[BW-1] && (rb[PW-1:0] > ctpr_n) &&
                 (!sb[BW-1] || rb[PW-1:0] > sb[PW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsd_q  <= '0;
      svc_q  <= '0;
      ctpr_q <= '1;
      rb_q   <= '0;
      sb_q   <= '0;
      int_q  <= 1'b0;
      for (int i = 0; i < NSRC; i++) pri_q[i] <= '0;
    end else begin
      rsd_q  <= rsd_n;
      svc_q  <= svc_n;
      ctpr_q <= ctpr_n;
      rb_q   <= rb;
      sb_q   <= sb;
      int_q  <= int_n;
      pri_q  <= pri_n;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    localparam logic [1:0] CODE = 2'(g + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[g] <= '0;
      else if (evt_valid && evt_out == CODE) begin
        if (evt_active && !evt_was_active && cnt_q[g] != '1)
          cnt_q[g] <= cnt_q[g] + 1'b1;
        else if (!evt_active && evt_was_active && cnt_q[g] != '0)
          cnt_q[g] <= cnt_q[g] - 1'b1;
      end
    end
  end

  assign int_o      = int_q;
  assign crit_o     = cnt_q[0] != '0;
  assign mcp_o      = cnt_q[1] != '0;
  assign rsd_best_o = rb_q[BW-1] ? {1'b0, rb_q[BW-2:PW]} : '1;
  assign rsd_pri_o  = rb_q[BW-1] ? {1'b0, rb_q[PW-1:0]} : '1;
  assign svc_best_o = sb_q[BW-1] ? {1'b0, sb_q[BW-2:PW]} : '1;
  assign svc_pri_o  = sb_q[BW-1] ? {1'b0, sb_q[PW-1:0]} : '1;

  a_r4_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> rsd_best_o != '1);
  a_r4_int_above_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && svc_best_o != '1) |-> rsd_pri_o > svc_pri_o);
  a_r8_crit_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crit_o) |-> $past(evt_valid && evt_out == 2'd1 && evt_active && !evt_was_active));
  a_r8_crit_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crit_o) |-> $past(evt_valid && evt_out == 2'd1 && !evt_active && evt_was_active));
  a_r9_mcp_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mcp_o) |-> $past(evt_valid && evt_out == 2'd2 && evt_active && !evt_was_active));
  a_r9_mcp_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mcp_o) |-> $past(evt_valid && evt_out == 2'd2 && !evt_active && evt_was_active));
  a_r10_special_keeps_int: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_out != OUT_NORM && !ctpr_we && !svc_we) |=> $stable(int_o));
endmodule

// File: tb/prio_deliver_test.sv
module prio_deliver_test;
  localparam int NSRC = 64;
  localparam int PW = 4;
  localparam int IW = $clog2(NSRC);

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 0, evt_active = 0, evt_was_active = 0;
  logic [1:0] evt_out = 0;
  logic [IW-1:0] evt_src = 0, svc_src = 0;
  logic [PW-1:0] evt_prio = 0, ctpr_data = 0;
  logic ctpr_we = 0, svc_we = 0, svc_set = 0;
  logic int_o, crit_o, mcp_o;
  logic [IW:0] rsd_best_o, svc_best_o;
  logic [PW:0] rsd_pri_o, svc_pri_o;

  int checks = 0, failures = 0;
  bit done = 0;

  bit m_rsd [NSRC];
  bit m_svc [NSRC];
  int m_pri [NSRC];
  int m_ctpr = 15, m_crit = 0, m_mcp = 0;

  prio_deliver #(.NSRC(NSRC), .PW(PW)) uut (.*);

  always #5 clk = ~clk;

  function automatic int best_idx(input bit s [NSRC]);
    int bi = -1, bp = -1;
    for (int i = 0; i < NSRC; i++)
      if (s[i] && m_pri[i] > bp) begin bi = i; bp = m_pri[i]; end
    return bi;
  endfunction

  task automatic check(input string req);
    int ri, si, rp, sp;
    bit ei;
    logic [3+2*(IW+1)+2*(PW+1)-1:0] act, exp;
    ri = best_idx(m_rsd);
    si = best_idx(m_svc);
    rp = (ri < 0) ? -1 : m_pri[ri];
    sp = (si < 0) ? -1 : m_pri[si];
    ei = (rp > m_ctpr) && (rp > sp);
    exp = {ei, m_crit != 0, m_mcp != 0, (IW+1)'(ri), (PW+1)'(rp), (IW+1)'(si), (PW+1)'(sp)};
    act = {int_o, crit_o, mcp_o, rsd_best_o, rsd_pri_o, svc_best_o, svc_pri_o};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    evt_valid = 0; ctpr_we = 0; svc_we = 0;
  endtask

  task automatic event_go(input int src, input int prio, input int out,
                          input bit act, input bit was);
    @(negedge clk);
    evt_valid = 1; evt_src = IW'(src); evt_prio = PW'(prio);
    evt_out = 2'(out); evt_active = act; evt_was_active = was;
    step();
    if (out == 0) begin
      m_rsd[src] = act;
      if (act) m_pri[src] = prio;
    end else if (out == 1) begin
      if (act && !was) m_crit++;
      else if (!act && was && m_crit > 0) m_crit--;
    end else if (out == 2) begin
      if (act && !was) m_mcp++;
      else if (!act && was && m_mcp > 0) m_mcp--;
    end
  endtask

  task automatic set_ctpr(input int v);
    @(negedge clk);
    ctpr_we = 1; ctpr_data = PW'(v);
    step();
    m_ctpr = v;
  endtask

  task automatic set_svc(input int src, input bit v);
    @(negedge clk);
    svc_we = 1; svc_src = IW'(src); svc_set = v;
    step();
    m_svc[src] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSRC; i++) begin m_rsd[i] = 0; m_svc[i] = 0; m_pri[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset");

    for (int c = 0; c < 16; c++) begin
      set_ctpr(c);
      check("R6 ctpr write");
      for (int p = 0; p < 16; p++) begin
        event_go(5, p, 0, 1, 0);
        check("R2 R4 activation vs ctpr");
        event_go(5, p, 0, 0, 1);
        check("R5 deactivation");
      end
    end

    set_ctpr(0);
    event_go(10, 7, 0, 1, 0); check("R3 single");
    event_go(3, 7, 0, 1, 0);  check("R3 tie lowest index");
    event_go(40, 9, 0, 1, 0); check("R3 higher priority");
    event_go(40, 9, 0, 0, 1); check("R5 remaining best");
    event_go(3, 7, 0, 0, 1);  check("R5 remaining best");
    event_go(10, 7, 0, 0, 1); check("R3 empty set");

    set_ctpr(15);
    event_go(2, 6, 0, 1, 0);  check("R2 held source recorded");
    set_ctpr(5);              check("R6 lowered ctpr releases");
    set_ctpr(6);              check("R6 equal ctpr holds");
    set_ctpr(0);              check("R6 release");

    set_svc(2, 1);            check("R7 in-service hides equal");
    event_go(8, 6, 0, 1, 0);  check("R7 equal priority hidden");
    event_go(9, 7, 0, 1, 0);  check("R7 higher priority passes");
    event_go(9, 7, 0, 0, 1);  check("R7 hidden again");
    set_svc(2, 0);            check("R7 in-service cleared");

    event_go(20, 3, 1, 1, 0); check("R8 crit raise");
    event_go(21, 3, 1, 1, 0); check("R8 crit count two");
    event_go(21, 3, 1, 1, 1); check("R8 already active no count");
    event_go(20, 3, 1, 0, 1); check("R8 crit stays");
    event_go(21, 3, 1, 0, 1); check("R8 crit lowers");
    event_go(21, 3, 1, 0, 1); check("R8 no underflow");
    event_go(22, 1, 2, 1, 0); check("R9 mcp raise");
    event_go(22, 1, 2, 0, 0); check("R9 inactive to inactive");
    event_go(22, 1, 2, 0, 1); check("R9 mcp lowers");
    event_go(30, 15, 1, 1, 0); check("R10 crit leaves sets");
    event_go(30, 15, 1, 0, 1); check("R10 crit leaves sets");
    event_go(31, 15, 3, 1, 0); check("R10 type 3 ignored");
    event_go(2, 6, 0, 0, 1);  check("R11 one-edge latency");
    event_go(8, 6, 0, 0, 1);  check("R11 one-edge latency");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule